// File: doc/BRIEF.md
# Multi-Master Bus Arbiter with Split Tracking

This block decides which of several bus masters may drive the shared address phase of an AHB-style bus. Each master raises a request line. The arbiter answers with a one-hot grant vector and an owner index. Ownership passes to another master only on a clock edge where the bus-ready signal is high, so a transfer that a slave is still stalling keeps its owner.

A slave can park a slow transfer by returning a SPLIT response. When that happens, the arbiter removes the owning master from arbitration. The master stays out of arbitration, whatever it requests, until a slave signals through its release vector that the parked transfer can now finish. Release vectors from all slaves are combined. A released master then goes ahead of ordinary requesters at its next chance.

When no master is eligible, the grant falls to a default master, master 0, which keeps the bus busy with idle transfers.

Top module: `bus_owner_arbiter`

## Requirements
- R1: After reset the grant vector is one-hot on master 0 and the owner index is 0. The grant vector is always exactly one-hot.
- R2: Grant and owner keep their values across every clock edge where `bus_ready_i` is low.
- R3: On an edge where `bus_ready_i` is high, the owner index takes the index of the master that was granted just before that edge.
- R4: Among eligible requesters (request high, not split-parked), the grant goes to the lowest index on each edge where `bus_ready_i` is high.
- R5: A SPLIT response (`bus_resp_i` = 2'b11 on an edge with `bus_ready_i` high) parks the master named by the owner index. That master is not granted on that edge. It is also not granted on any later edge while it stays parked, even with its request high.
- R6: The release inputs of all slaves are ORed per master (bit m of slave s is bit s*N+m of `split_release_i`). A set bit unparks master m on that edge, and the master takes part in arbitration from the next edge on.
- R7: A master that was unparked by a release bit wins over ordinary requesters, even ones of lower index, until it is granted. Among several such masters, the lowest index wins.
- R8: When no master is eligible, master 0 is granted. This holds even if master 0 is parked.
- R9: Responses OKAY (2'b00), ERROR (2'b01) and RETRY (2'b10) park no master. The owner can be granted again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req_i | input | N_MASTERS | Per-master bus request |
| bus_ready_i | input | 1 | Bus ready; the current transfer phase ends |
| bus_resp_i | input | 2 | Slave response code, 2'b11 = SPLIT |
| split_release_i | input | N_SLAVES*N_MASTERS | Per-slave release vectors, one bit per master |
| grant_o | output | N_MASTERS | One-hot bus grant |
| owner_o | output | clog2(N_MASTERS) | Index of the master owning the address phase |

## Verification
A parked bit that is stuck or lost shows up at the ports on the very next ready edge. If the bit is stuck, a requesting split master never gets the grant back. If the bit is lost, a master just answered with SPLIT is granted again, which it must not be. A promotion flag that is missing or stale shows up as the wrong winner on the edge after a release, when a lower-index master competes. An owner register that misses its ready qualification drifts away from the grant while the bus is stalled. The sequences put each of these cases next to a competing requester, so that a wrong state changes the grant and does not stay hidden.

// File: rtl/arb_pkg.sv
// Shared types for the bus arbiter: slave response encoding.
package arb_pkg;
    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } resp_e;
endpackage

// File: rtl/arb_priority_pick.sv
// Picks the winning master index from an eligibility vector.
// Assumes: promoted masters (released from split) take precedence over
// plain eligible ones; lowest index wins inside either group; DEFAULT_IDX
// is returned when no bit is set.
module arb_priority_pick #(
    parameter int N           = 4,
    parameter int DEFAULT_IDX = 0,
    localparam int IDW        = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   eligible_i,
    input  logic [N-1:0]   promoted_i,
    output logic [IDW-1:0] pick_o,
    output logic           any_o
);
    logic [N-1:0] cand;

    // Choose the candidate group: promoted eligibles first, else all eligibles.
    always_comb begin
        if (|(eligible_i & promoted_i)) cand = eligible_i & promoted_i;
        else                            cand = eligible_i;
    end

    // Lowest set index wins; fall back to the default master.
    always_comb begin
        pick_o = IDW'(DEFAULT_IDX);
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) pick_o = IDW'(i);
        end
    end

    assign any_o = |cand;
endmodule

// File: rtl/arb_split_tracker.sv
// Keeps the per-master split-park mask and the promotion flags.
// Assumes: release vectors of all slaves are ORed; a SPLIT sets the park
// bit of the current owner; a release bit clears the park bit and raises
// the promotion flag if the master was parked; a promotion flag drops when
// its master is granted on a ready edge. A new promotion set wins over a
// clear in the same cycle.
module arb_split_tracker #(
    parameter int N          = 4,
    parameter int NS         = 2,
    localparam int IDW       = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_evt_i,
    input  logic [IDW-1:0]   split_idx_i,
    input  logic [NS*N-1:0]  release_i,
    input  logic             take_i,
    input  logic [IDW-1:0]   take_idx_i,
    output logic [N-1:0]     parked_o,
    output logic [N-1:0]     promoted_o
);
    logic [N-1:0] release_any;
    logic [N-1:0] set_park;
    logic [N-1:0] clr_promo;

    // OR the release vectors of every slave into one per-master vector.
    always_comb begin
        release_any = '0;
        for (int s = 0; s < NS; s++) begin
            release_any = release_any | release_i[s*N +: N];
        end
    end

    // Decode the park-set and promotion-clear one-hot vectors.
    always_comb begin
        set_park  = '0;
        clr_promo = '0;
        for (int i = 0; i < N; i++) begin
            if (split_evt_i && (split_idx_i == IDW'(i))) set_park[i]  = 1'b1;
            if (take_i && (take_idx_i == IDW'(i)))       clr_promo[i] = 1'b1;
        end
    end

    // Update park mask and promotion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parked_o   <= '0;
            promoted_o <= '0;
        end else begin
            parked_o   <= (parked_o & ~release_any) | set_park;
            promoted_o <= (promoted_o & ~clr_promo) | (parked_o & release_any);
        end
    end
endmodule

// File: rtl/bus_owner_arbiter.sv
// Top of the multi-master bus arbiter with split tracking.
// Assumes: handover happens only on edges where bus_ready_i is high; the
// response is attributed to the master shown on owner_o; master
// DEFAULT_IDX is granted whenever nobody is eligible.
module bus_owner_arbiter #(
    parameter int N_MASTERS   = 4,
    parameter int N_SLAVES    = 2,
    parameter int DEFAULT_IDX = 0,
    localparam int IDW        = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_MASTERS-1:0]          bus_req_i,
    input  logic                          bus_ready_i,
    input  logic [1:0]                    bus_resp_i,
    input  logic [N_SLAVES*N_MASTERS-1:0] split_release_i,
    output logic [N_MASTERS-1:0]          grant_o,
    output logic [IDW-1:0]                owner_o
);
    import arb_pkg::*;

    logic [IDW-1:0]       grant_idx_q;
    logic [IDW-1:0]       pick_idx;
    logic                 pick_any;
    logic                 split_now;
    logic [N_MASTERS-1:0] parked;
    logic [N_MASTERS-1:0] promoted;
    logic [N_MASTERS-1:0] owner_oh;
    logic [N_MASTERS-1:0] eligible;

    // A SPLIT counts only when the transfer phase actually ends.
    assign split_now = bus_ready_i && (resp_e'(bus_resp_i) == RSP_SPLIT);

    // One-hot forms of the owner and the registered grant.
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
        assign owner_oh[g] = (owner_o == IDW'(g));
        assign grant_o[g]  = (grant_idx_q == IDW'(g));
    end

    // Eligible: requesting, not parked, and not the owner being split now.
    assign eligible = bus_req_i & ~parked & ~(split_now ? owner_oh : '0);

    arb_split_tracker #(
        .N (N_MASTERS),
        .NS(N_SLAVES)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .split_evt_i(split_now),
        .split_idx_i(owner_o),
        .release_i  (split_release_i),
        .take_i     (bus_ready_i),
        .take_idx_i (pick_idx),
        .parked_o   (parked),
        .promoted_o (promoted)
    );

    arb_priority_pick #(
        .N          (N_MASTERS),
        .DEFAULT_IDX(DEFAULT_IDX)
    ) u_pick (
        .eligible_i(eligible),
        .promoted_i(promoted),
        .pick_o    (pick_idx),
        .any_o     (pick_any)
    );

    // Hand over grant and owner on ready edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_idx_q <= IDW'(DEFAULT_IDX);
            owner_o     <= IDW'(DEFAULT_IDX);
        end else if (bus_ready_i) begin
            grant_idx_q <= pick_idx;
            owner_o     <= grant_idx_q;
        end
    end

    logic unused_any;
    assign unused_any = pick_any;
endmodule

// File: rtl/bus_owner_arbiter_chk.sv
// Property checker for bus_owner_arbiter, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module bus_owner_arbiter_chk #(
    parameter int N_MASTERS   = 4,
    parameter int DEFAULT_IDX = 0,
    localparam int IDW        = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] bus_req_i,
    input logic                 bus_ready_i,
    input logic [1:0]           bus_resp_i,
    input logic [N_MASTERS-1:0] grant_o,
    input logic [IDW-1:0]       owner_o
);
    logic [N_MASTERS-1:0] own_oh_c;
    logic [N_MASTERS-1:0] dflt_oh;

    // One-hot views of the owner and of the default master.
    always_comb begin
        own_oh_c = '0;
        dflt_oh  = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (owner_o == IDW'(i)) own_oh_c[i] = 1'b1;
            if (DEFAULT_IDX == i)   dflt_oh[i]  = 1'b1;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1); // R1

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready_i |=> ($stable(grant_o) && $stable(owner_o))); // R2

    AST_OWNER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready_i |=> (own_oh_c == $past(grant_o))); // R3

    AST_SPLIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready_i && bus_resp_i == 2'b11 && (own_oh_c != dflt_oh))
        |=> (grant_o != $past(own_oh_c))); // R5

    AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready_i && bus_req_i == '0) |=> (grant_o == dflt_oh)); // R8
endmodule

bind bus_owner_arbiter bus_owner_arbiter_chk #(
    .N_MASTERS  (N_MASTERS),
    .DEFAULT_IDX(DEFAULT_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req_i  (bus_req_i),
    .bus_ready_i(bus_ready_i),
    .bus_resp_i (bus_resp_i),
    .grant_o    (grant_o),
    .owner_o    (owner_o)
);

// File: tb/bus_owner_arbiter_bench.sv
// Scoreboard bench: the driver task applies one cycle of stimulus, advances
// a reference model written from the requirements and queues the expected
// grant/owner; the monitor pops and compares after each rising edge.
module bus_owner_arbiter_bench;
    localparam int N  = 4;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          rdy = 1'b1;
    logic [1:0]    resp = 2'b00;
    logic [NS*N-1:0] rel = '0;
    logic [N-1:0]  grant;
    logic [1:0]    owner;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [N-1:0] grant;
        logic [1:0]   owner;
        string        tag;
    } exp_t;
    exp_t sb[$];

    // reference model state
    int           m_grant = 0;
    int           m_owner = 0;
    logic [N-1:0] m_park  = '0;
    logic [N-1:0] m_promo = '0;

    always #4 clk = ~clk;   // 125 MHz

    bus_owner_arbiter #(.N_MASTERS(N), .N_SLAVES(NS), .DEFAULT_IDX(0)) u_bus_owner_arbiter (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_req_i      (req),
        .bus_ready_i    (rdy),
        .bus_resp_i     (resp),
        .split_release_i(rel),
        .grant_o        (grant),
        .owner_o        (owner)
    );

    task automatic step(input logic [N-1:0] r, input logic y, input logic [1:0] rs,
                        input logic [NS*N-1:0] w, input string tag);
        logic [N-1:0] elig, cand, wake, promo_n, park_n;
        int p;
        exp_t e;
        @(negedge clk);
        req = r; rdy = y; resp = rs; rel = w;
        wake = w[N-1:0] | w[2*N-1:N];
        elig = r & ~m_park;
        if (y && rs == 2'b11) elig[m_owner] = 1'b0;
        cand = (|(elig & m_promo)) ? (elig & m_promo) : elig;
        p = 0;
        for (int i = N - 1; i >= 0; i--) if (cand[i]) p = i;
        promo_n = m_promo;
        if (y) promo_n[p] = 1'b0;
        promo_n = promo_n | (m_park & wake);
        park_n = m_park & ~wake;
        if (y && rs == 2'b11) park_n[m_owner] = 1'b1;
        m_park = park_n;
        m_promo = promo_n;
        if (y) begin
            m_owner = m_grant;
            m_grant = p;
        end
        e.grant = '0;
        e.grant[m_grant] = 1'b1;
        e.owner = 2'(m_owner);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare design outputs with queued expectations after each edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (grant !== e.grant || owner !== e.owner) begin
                n_bad++;
                $display("FAIL %s: grant=%b owner=%0d expected grant=%b owner=%0d",
                         e.tag, grant, owner, e.grant, e.owner);
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if (grant !== 4'b0001 || owner !== 2'd0) begin   // R1 reset state
            n_bad++;
            $display("FAIL R1: grant=%b owner=%0d expected grant=0001 owner=0", grant, owner);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0100, 1, 2'b00, '0, "R4");
        step(4'b1010, 1, 2'b00, '0, "R4");
        step(4'b1010, 0, 2'b00, '0, "R2");
        step(4'b0001, 0, 2'b00, '0, "R2");
        step(4'b1010, 1, 2'b00, '0, "R3");
        step(4'b1010, 1, 2'b00, '0, "R3");
        // owner is now master 1: split it
        step(4'b1010, 1, 2'b11, '0, "R5");
        step(4'b1010, 1, 2'b00, '0, "R5");
        step(4'b0010, 1, 2'b00, '0, "R5");
        step(4'b0010, 1, 2'b00, '0, "R8");
        // retry on owner: no park
        step(4'b1000, 1, 2'b00, '0, "R9");
        step(4'b1000, 1, 2'b00, '0, "R9");
        step(4'b1000, 1, 2'b10, '0, "R9");
        step(4'b1000, 1, 2'b01, '0, "R9");
        step(4'b1000, 1, 2'b00, '0, "R9");
        // release master 1 from slave 1, master 0 competes
        step(4'b0011, 1, 2'b00, 8'b0010_0000, "R6");
        step(4'b0011, 1, 2'b00, '0, "R7");
        step(4'b0011, 1, 2'b00, '0, "R7");
        step(4'b0011, 1, 2'b00, '0, "R4");
        // idle: default master
        step(4'b0000, 1, 2'b00, '0, "R8");
        step(4'b0000, 1, 2'b00, '0, "R8");
        // split master 2 then it requests alone
        step(4'b0100, 1, 2'b00, '0, "R4");
        step(4'b0100, 1, 2'b00, '0, "R4");
        step(4'b0100, 1, 2'b11, '0, "R5");
        step(4'b0100, 1, 2'b00, '0, "R8");
        step(4'b0100, 0, 2'b00, '0, "R2");
        // release master 2 via slave 0 while master 3 requests
        step(4'b1100, 1, 2'b00, 8'b0000_0100, "R6");
        step(4'b1100, 1, 2'b00, '0, "R7");
        step(4'b1100, 1, 2'b00, '0, "R4");
        step(4'b0000, 1, 2'b00, '0, "R8");
        repeat (3) @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule